// File: doc/BRIEF.md
# DMA Channel Bus Arbiter

This block decides, one transfer unit at a time, who owns the system bus: the CPU or one of four DMA channels. Each channel carries its own enable, a mode bit choosing burst or cycle-steal operation, a request-source select (an external request pin or an internal request strobe) and an address-mode bit. The arbiter presents a one-hot grant and, next to it, the number of extra wait states the bus controller should insert for the granted channel's bus cycles.

Ownership moves only when the granted channel signals the end of a transfer unit. The CPU is the default owner and gives up the bus as soon as a channel's request has been recorded. Channels are ranked by a fixed priority. A higher-priority channel can break into a burst at a unit boundary. When the intruder runs cycle-steal units, it and the burst channel take turns unit by unit. As long as a burst channel still has work, the CPU stays off the bus. A cycle-steal channel with no competition hands the bus back to the CPU after each unit.

Top module: `dma_bus_arbiter`

## Requirements
- R1: Exactly one of `grant_cpu` and the four `grant_ch` bits is high in every cycle. After reset the CPU holds the grant and `wait_states` is 0.
- R2: Several channels may be waiting while the CPU owns the bus. They are then served in the fixed order channel 0, channel 3, channel 2, channel 1 (bit n of `grant_ch` is channel n).
- R3: While a channel holds the grant, the grant changes only in the cycle after that channel's own `unit_done` pulse. A `unit_done` pulse from a channel that is not granted has no effect.
- R4: A burst channel may be serving when a higher-priority burst channel requests. The higher one takes the bus at the next unit boundary and keeps it until its `xfer_done`. The lower one then resumes.
- R5: A higher-priority cycle-steal channel that requests during a lower burst channel's transfer alternates with it one unit each, for as long as it re-requests.
- R6: While any burst-mode channel has an active transfer, the grant never passes to the CPU at a unit boundary.
- R7: A cycle-steal channel's request covers one unit. With no other channel active, the bus returns to the CPU after that unit. A request the channel raises during its own granted unit is dropped.
- R8: An internal request pulse in cycle c gives a grant visible after the second rising edge from c. An external pin level sampled at a rising edge gives a grant no earlier than two clock edges after that sampling edge.
- R9: `wait_states` equals `wait_dual` when the granted channel has `ch_dual`=1, equals `wait_single` when it has `ch_dual`=0, and is 0 while the CPU owns the bus.
- R10: Requests from a channel whose `ch_en` bit is 0 are discarded and are not remembered once the channel is enabled.
- R11: An `xfer_done` pulse ends a channel's active transfer even when that channel is not granted, so the channel is not served afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ch_en | input | 4 | Per-channel enable |
| ch_burst | input | 4 | Per-channel mode: 1 burst, 0 cycle-steal |
| ch_ext_sel | input | 4 | Request source: 1 external pin, 0 internal strobe |
| ch_dual | input | 4 | Address mode: 1 dual, 0 single |
| ext_req | input | 4 | External request pins, sampled on the rising edge |
| int_req | input | 4 | Internal request strobes |
| unit_done | input | 4 | Transfer-unit finished, from the channel engine |
| xfer_done | input | 4 | Whole transfer finished, from the channel engine |
| wait_dual | input | 2 | Extra wait states for dual-address cycles |
| wait_single | input | 2 | Extra wait states for single-address cycles |
| grant_cpu | output | 1 | CPU owns the bus |
| grant_ch | output | 4 | One-hot channel grant |
| wait_states | output | 2 | Extra wait states for the current owner |

## Verification
The assertions assume that `unit_done` and `xfer_done` are single-cycle pulses, and that a channel pulses `xfer_done` together with or after its final `unit_done`. They also assume that mode and address-mode bits do not change while a channel is active. The directed tasks hold the configuration fixed for the length of each scenario. They raise completion pulses only for the granted channel, apart from the single deliberate stray `unit_done` and the deliberate early `xfer_done` used to exercise R3 and R11. Every request is a one-cycle pulse driven between clock edges.

// File: rtl/dmarb_pkg.sv
// Shared constants and helpers for the DMA bus arbiter.
// Assumes exactly four channels; the fixed ranking is encoded in prio_chan.
package dmarb_pkg;
    localparam int NCH   = 4;
    localparam int IDX_W = $clog2(NCH);

    typedef logic [NCH-1:0]   chvec_t;
    typedef logic [IDX_W-1:0] chidx_t;

    // Channel index holding a given priority rank (rank 0 wins).
    function automatic chidx_t prio_chan(input int rank);
        case (rank)
            0:       return chidx_t'(0);
            1:       return chidx_t'(3);
            2:       return chidx_t'(2);
            default: return chidx_t'(1);
        endcase
    endfunction

    // One-hot of the best-ranked set bit of cand, zero if none.
    function automatic chvec_t pick_first(input chvec_t cand);
        chvec_t res = '0;
        logic   hit = 1'b0;
        for (int r = 0; r < NCH; r++) begin
            if (!hit && cand[prio_chan(r)]) begin
                res[prio_chan(r)] = 1'b1;
                hit = 1'b1;
            end
        end
        return res;
    endfunction
endpackage

// File: rtl/dmarb_req_front.sv
// Request front end: registers the external pins once (sampling edge),
// chooses the request source per channel and gates it with the enable.
// Assumes ext_req is already synchronous to clk.
module dmarb_req_front
    import dmarb_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] en,
    input  logic [N-1:0] ext_sel,
    input  logic [N-1:0] ext_req,
    input  logic [N-1:0] int_req,
    output logic [N-1:0] req_vld
);
    logic [N-1:0] ext_smp;

    for (genvar i = 0; i < N; i++) begin : g_ch
        // Sample the external pin on the rising edge.
        always_ff @(posedge clk) begin
            if (!rst_n) ext_smp[i] <= 1'b0;
            else        ext_smp[i] <= ext_req[i];
        end

        // Pick the request source and drop it when disabled.
        always_comb begin
            req_vld[i] = en[i] & (ext_sel[i] ? ext_smp[i] : int_req[i]);
        end
    end
endmodule

// File: rtl/dmarb_activity.sv
// Per-channel activity tracking. A channel becomes active on a valid
// request; a burst channel stays active until xfer_done, a cycle-steal
// channel only until the end of its granted unit. Clears beat sets.
// Assumes owner is the registered one-hot channel grant.
module dmarb_activity
    import dmarb_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_vld,
    input  logic [N-1:0] burst,
    input  logic [N-1:0] owner,
    input  logic [N-1:0] unit_done,
    input  logic [N-1:0] xfer_done,
    output logic [N-1:0] want_q,
    output logic [N-1:0] drop
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        // Decide whether this channel's activity ends this cycle.
        always_comb begin
            drop[i] = xfer_done[i] | (owner[i] & unit_done[i] & ~burst[i]);
        end

        // Hold, set or clear the activity flag.
        always_ff @(posedge clk) begin
            if (!rst_n)       want_q[i] <= 1'b0;
            else if (drop[i]) want_q[i] <= 1'b0;
            else if (req_vld[i]) want_q[i] <= 1'b1;
        end

        // R11: a completed transfer leaves the channel idle.
        p_done_idles_r11: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_done[i] |=> !want_q[i]);
    end
endmodule

// File: rtl/dmarb_pick.sv
// Next-owner selection. Normally the best-ranked active channel wins;
// after a cycle-steal unit, active burst channels get the next unit so
// the two alternate. Pure combinational logic.
module dmarb_pick
    import dmarb_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic [N-1:0] cand,
    input  logic [N-1:0] burst,
    input  logic         owner_cs,
    output logic [N-1:0] pick,
    output logic         pick_any
);
    logic [N-1:0] burst_cand;
    logic [N-1:0] pool;

    // Restrict the pool to burst channels when handing back after a steal.
    always_comb begin
        burst_cand = cand & burst;
        pool       = (owner_cs && (|burst_cand)) ? burst_cand : cand;
        pick       = pick_first(pool);
        pick_any   = |cand;
    end
endmodule

// File: rtl/dmarb_grant.sv
// Grant register and wait-state selection. The CPU yields whenever a
// candidate exists; a channel yields only on its own unit_done.
// Assumes cand already excludes channels ending this cycle.
module dmarb_grant
    import dmarb_pkg::*;
#(
    parameter int N    = NCH,
    parameter int WS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    pick,
    input  logic            pick_any,
    input  logic [N-1:0]    unit_done,
    input  logic [N-1:0]    burst,
    input  logic [N-1:0]    dual,
    input  logic [N-1:0]    cand,
    input  logic [N-1:0]    want_q,
    input  logic [WS_W-1:0] wait_dual,
    input  logic [WS_W-1:0] wait_single,
    output logic            grant_cpu,
    output logic [N-1:0]    grant_ch,
    output logic            owner_cs,
    output logic [WS_W-1:0] wait_states
);
    logic boundary;

    // Detect the end of the granted channel's unit.
    always_comb begin
        boundary = |(grant_ch & unit_done);
        owner_cs = |(grant_ch & ~burst);
    end

    // Move ownership at a unit boundary or away from an idle CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_cpu <= 1'b1;
            grant_ch  <= '0;
        end else if (grant_cpu || boundary) begin
            grant_cpu <= ~pick_any;
            grant_ch  <= pick_any ? pick : '0;
        end
    end

    // Select the wait-state setting from the owner's address mode.
    always_comb begin
        wait_states = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_ch[i]) wait_states = dual[i] ? wait_dual : wait_single;
        end
    end

    // R1: one owner at all times.
    p_one_owner_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({grant_cpu, grant_ch}) == 1);

    // R3: a channel keeps the bus until its own unit ends.
    p_hold_in_unit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_cpu && !boundary) |=> $stable(grant_ch));

    // R6: a pending burst keeps the CPU off the bus at a boundary.
    p_burst_keeps_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && (|(cand & burst))) |=> !grant_cpu);

    // R7: a lone cycle-steal unit hands the bus back to the CPU.
    p_steal_returns_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && owner_cs && !(|cand)) |=> grant_cpu);

    // R8: no channel is granted before its request was recorded.
    p_grant_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|grant_ch) |-> $past(|want_q));

    // R9: the CPU never runs with DMA wait states.
    p_cpu_no_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_cpu |-> (wait_states == '0));
endmodule

// File: rtl/dma_bus_arbiter.sv
// Top of the DMA bus arbiter: request front end, activity tracking,
// next-owner selection and grant register. Four channels, fixed rank
// 0 > 3 > 2 > 1. Assumes completion pulses come from the engines.
module dma_bus_arbiter
    import dmarb_pkg::*;
#(
    parameter int WS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  ch_en,
    input  logic [NCH-1:0]  ch_burst,
    input  logic [NCH-1:0]  ch_ext_sel,
    input  logic [NCH-1:0]  ch_dual,
    input  logic [NCH-1:0]  ext_req,
    input  logic [NCH-1:0]  int_req,
    input  logic [NCH-1:0]  unit_done,
    input  logic [NCH-1:0]  xfer_done,
    input  logic [WS_W-1:0] wait_dual,
    input  logic [WS_W-1:0] wait_single,
    output logic            grant_cpu,
    output logic [NCH-1:0]  grant_ch,
    output logic [WS_W-1:0] wait_states
);
    logic [NCH-1:0] req_vld;
    logic [NCH-1:0] want_q;
    logic [NCH-1:0] drop;
    logic [NCH-1:0] cand;
    logic [NCH-1:0] pick;
    logic           pick_any;
    logic           owner_cs;

    // Candidates for the next grant: active and not ending now.
    always_comb begin
        cand = want_q & ~drop;
    end

    dmarb_req_front #(.N(NCH)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ch_en),
        .ext_sel (ch_ext_sel),
        .ext_req (ext_req),
        .int_req (int_req),
        .req_vld (req_vld)
    );

    dmarb_activity #(.N(NCH)) u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_vld   (req_vld),
        .burst     (ch_burst),
        .owner     (grant_ch),
        .unit_done (unit_done),
        .xfer_done (xfer_done),
        .want_q    (want_q),
        .drop      (drop)
    );

    dmarb_pick #(.N(NCH)) u_pick (
        .cand     (cand),
        .burst    (ch_burst),
        .owner_cs (owner_cs),
        .pick     (pick),
        .pick_any (pick_any)
    );

    dmarb_grant #(.N(NCH), .WS_W(WS_W)) u_grant (
        .clk         (clk),
        .rst_n       (rst_n),
        .pick        (pick),
        .pick_any    (pick_any),
        .unit_done   (unit_done),
        .burst       (ch_burst),
        .dual        (ch_dual),
        .cand        (cand),
        .want_q      (want_q),
        .wait_dual   (wait_dual),
        .wait_single (wait_single),
        .grant_cpu   (grant_cpu),
        .grant_ch    (grant_ch),
        .owner_cs    (owner_cs),
        .wait_states (wait_states)
    );

    // R10: a disabled channel is never newly granted by the CPU.
    p_disabled_no_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_cpu && !(|want_q)) |=> grant_cpu);
endmodule

// File: tb/sim_dma_bus_arbiter.sv
// Directed bench for dma_bus_arbiter: one task per scenario.
module sim_dma_bus_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ch_en = 4'hF;
    logic [3:0] ch_burst = '0;
    logic [3:0] ch_ext_sel = '0;
    logic [3:0] ch_dual = '0;
    logic [3:0] ext_req = '0;
    logic [3:0] int_req = '0;
    logic [3:0] unit_done = '0;
    logic [3:0] xfer_done = '0;
    logic [1:0] wait_dual = 2'd2;
    logic [1:0] wait_single = 2'd1;
    logic       grant_cpu;
    logic [3:0] grant_ch;
    logic [1:0] wait_states;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    localparam logic [4:0] CPU = 5'b10000;

    dma_bus_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_burst(ch_burst),
        .ch_ext_sel(ch_ext_sel), .ch_dual(ch_dual), .ext_req(ext_req),
        .int_req(int_req), .unit_done(unit_done), .xfer_done(xfer_done),
        .wait_dual(wait_dual), .wait_single(wait_single),
        .grant_cpu(grant_cpu), .grant_ch(grant_ch), .wait_states(wait_states)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL R1 watchdog: actual %0d cycles, expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [4:0] CH(input int n);
        return 5'(1 << n);
    endfunction

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk_grant(input string req, input logic [4:0] exp);
        logic [4:0] got;
        got = {grant_cpu, grant_ch};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: grant actual %b expected %b", req, got, exp);
        end
    endtask

    task automatic chk_ws(input string req, input logic [1:0] exp);
        checks++;
        if (wait_states !== exp) begin
            errors++;
            $display("FAIL %s: wait_states actual %0d expected %0d", req, wait_states, exp);
        end
    endtask

    // One-cycle internal request pulse; returns one negedge later.
    task automatic pulse_int(input logic [3:0] m);
        int_req = m;
        step();
        int_req = '0;
    endtask

    // Granted channel ends a unit (and optionally its transfer).
    task automatic end_unit(input int ch, input logic last);
        unit_done[ch] = 1'b1;
        xfer_done[ch] = last;
        step();
        unit_done = '0;
        xfer_done = '0;
    endtask

    task automatic t_reset;
        chk_grant("R1 reset owner", CPU);
        chk_ws("R1 reset wait", 2'd0);
    endtask

    task automatic t_priority;
        ch_burst = '0;
        pulse_int(4'b1111);
        chk_grant("R8 internal latency, not yet", CPU);
        step();
        chk_grant("R2 first ch0", CH(0));
        end_unit(0, 1'b0);
        chk_grant("R2 then ch3", CH(3));
        end_unit(3, 1'b0);
        chk_grant("R2 then ch2", CH(2));
        end_unit(2, 1'b0);
        chk_grant("R2 then ch1", CH(1));
        end_unit(1, 1'b0);
        chk_grant("R7 back to CPU", CPU);
    endtask

    task automatic t_ext_wait;
        ch_ext_sel = 4'b1000;
        ch_dual = 4'b1000;
        ext_req = 4'b1000;
        step();
        ext_req = '0;
        chk_grant("R8 ext edge+0", CPU);
        step();
        chk_grant("R8 ext edge+1", CPU);
        step();
        chk_grant("R8 ext edge+2 granted", CH(3));
        chk_ws("R9 dual wait", 2'd2);
        end_unit(3, 1'b0);
        chk_grant("R7 cycle-steal release", CPU);
        chk_ws("R9 cpu wait", 2'd0);
        ch_ext_sel = '0;
        ch_dual = '0;
        pulse_int(4'b0010);
        step();
        chk_grant("R9 ch1 granted", CH(1));
        chk_ws("R9 single wait", 2'd1);
        end_unit(1, 1'b0);
        chk_grant("R7 ch1 release", CPU);
    endtask

    task automatic t_own_req;
        pulse_int(4'b0100);
        step();
        chk_grant("R7 ch2 granted", CH(2));
        pulse_int(4'b0100);
        end_unit(2, 1'b0);
        chk_grant("R7 unit end", CPU);
        step(3);
        chk_grant("R7 own-unit request dropped", CPU);
    endtask

    task automatic t_stray_done;
        ch_burst = 4'b0010;
        pulse_int(4'b0010);
        step();
        chk_grant("R3 ch1 burst granted", CH(1));
        unit_done[2] = 1'b1;
        step();
        unit_done = '0;
        chk_grant("R3 stray unit_done ignored", CH(1));
        step(3);
        chk_grant("R3 held inside unit", CH(1));
        end_unit(1, 1'b0);
        chk_grant("R6 burst keeps bus", CH(1));
        end_unit(1, 1'b1);
        chk_grant("R11 burst done to CPU", CPU);
        ch_burst = '0;
    endtask

    task automatic t_burst_preempt;
        ch_burst = 4'b0011;
        pulse_int(4'b0010);
        step();
        chk_grant("R4 ch1 burst", CH(1));
        pulse_int(4'b0001);
        end_unit(1, 1'b0);
        chk_grant("R4 ch0 preempts", CH(0));
        end_unit(0, 1'b0);
        chk_grant("R4 ch0 keeps bus", CH(0));
        end_unit(0, 1'b1);
        chk_grant("R4 ch1 resumes", CH(1));
        end_unit(1, 1'b1);
        chk_grant("R4 done to CPU", CPU);
        ch_burst = '0;
    endtask

    task automatic t_steal_alternate;
        ch_burst = 4'b0010;
        pulse_int(4'b0010);
        step();
        chk_grant("R5 ch1 burst", CH(1));
        pulse_int(4'b0100);
        end_unit(1, 1'b0);
        chk_grant("R5 ch2 steals", CH(2));
        pulse_int(4'b0100);
        end_unit(2, 1'b0);
        chk_grant("R5 R6 back to ch1 not CPU", CH(1));
        pulse_int(4'b0100);
        end_unit(1, 1'b0);
        chk_grant("R5 ch2 again", CH(2));
        end_unit(2, 1'b0);
        chk_grant("R5 ch1 again", CH(1));
        end_unit(1, 1'b1);
        chk_grant("R5 end to CPU", CPU);
        ch_burst = '0;
    endtask

    task automatic t_disabled;
        ch_en = 4'b1110;
        pulse_int(4'b0001);
        step(3);
        chk_grant("R10 disabled ignored", CPU);
        ch_en = 4'hF;
        step(2);
        chk_grant("R10 not remembered", CPU);
    endtask

    task automatic t_early_done;
        ch_burst = 4'b0011;
        pulse_int(4'b0011);
        step();
        chk_grant("R11 ch0 first", CH(0));
        xfer_done[1] = 1'b1;
        step();
        xfer_done = '0;
        end_unit(0, 1'b1);
        chk_grant("R11 ch1 cancelled", CPU);
        ch_burst = '0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_priority();
        t_ext_wait();
        t_own_req();
        t_stray_done();
        t_burst_preempt();
        t_steal_alternate();
        t_disabled();
        t_early_done();
        step(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule